// File: doc/BRIEF.md
# Prefixed Bit and Shift Unit

This block executes the second byte of a two-byte instruction in an 8-bit processor, after the prefix byte has already been fetched elsewhere. It decodes that sub-opcode into one of four groups: rotate, shift and swap; bit test; bit clear; and bit set. Each operation acts on one of eight operand slots. Seven slots are registers, and the register file supplies the selected register's value alongside the start strobe. The remaining slot is the byte in memory at the address held in HL. For that slot the unit reads the byte through a one-byte memory port, modifies it, and writes it back to the same address. The address itself stays with the surrounding core.

A small state machine sequences the work. S_IDLE accepts `start` and latches the sub-opcode, the operand and the flags. It goes to S_FETCH when the slot is memory and to S_EXEC otherwise. S_FETCH holds `mem_rd` until `mem_rvalid` arrives, then goes to S_EXEC. S_EXEC registers the result and the new flags, then goes to S_FIN. S_FIN presents `done`, the write-back or memory write, and the flags for one cycle, then returns to S_IDLE.

An accumulator-only mode (`acc_only`) reuses the rotate datapath for the short unprefixed rotates. In that mode the operand is always the accumulator and Z is always cleared.

Top module: `pfx_bitops_unit`

## Requirements
- R1: Sub-opcode bits [7:6] select the group (0 rotate/shift/swap, 1 test, 2 clear, 3 set), bits [5:3] select the operation or bit index, and bits [2:0] select the slot, in the order B=0, C=1, D=2, E=3, H=4, L=5, memory=6, A=7. `wb_slot` reports that slot. Flags are packed as [3]=Z, [2]=N, [1]=H, [0]=C. For a register slot, `done` rises two clock edges after the edge that samples `start`.
- R2: Rotate codes (bits [5:3]) 0 (circular left) and 2 (left through carry) move bit 7 into C. Bit 0 receives old bit 7 for code 0 and old C for code 2.
- R3: Rotate codes 1 (circular right) and 3 (right through carry) move bit 0 into C. Bit 7 receives old bit 0 for code 1 and old C for code 3.
- R4: Shift code 4 shifts left with zero fill and moves bit 7 to C. Code 5 shifts right, keeps bit 7, and moves bit 0 to C. Code 7 shifts right with zero fill in bit 7 and moves bit 0 to C.
- R5: Code 6 exchanges the two nibbles and clears C. Every group-0 operation clears N and H and sets Z exactly when the result is zero.
- R6: Bit test sets Z to the inverse of the selected bit, clears N, sets H, keeps C, and writes nothing: `wb_en` and `mem_wr` stay low while `flags_we` is high.
- R7: Bit clear and bit set change only the bit chosen by bits [5:3]. They assert `flags_we` low and return `flags_out` equal to the flags given at start.
- R8: For the memory slot, `mem_rd` stays high from the cycle after `start` until the cycle in which `mem_rvalid` is seen. The modified byte appears on `mem_wdata` with `mem_wr` high in the `done` cycle, two edges after the `mem_rvalid` edge, and `wb_en` stays low.
- R9: With `acc_only` high, bits [5:3] pick a group-0 operation, the slot is forced to A (7) even when bits [2:0] are 6, no memory access is made, and Z is always 0.
- R10: `done` is a one-cycle pulse, and `start` is ignored while an operation is in progress.
- R11: After reset, `done`, `wb_en`, `flags_we`, `mem_rd` and `mem_wr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled in S_IDLE) |
| acc_only | input | 1 | Accumulator-only rotate mode |
| sub_op | input | 8 | Sub-opcode |
| rf_rdata | input | 8 | Value of the selected register slot |
| flags_in | input | 4 | Current flags {Z,N,H,C} |
| mem_rd | output | 1 | Memory read request for the HL byte |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Byte to write back |
| wb_en | output | 1 | Register write-back enable |
| wb_slot | output | 3 | Destination slot |
| wb_data | output | 8 | Result value |
| flags_we | output | 1 | Flag update enable |
| flags_out | output | 4 | New flags {Z,N,H,C} |
| done | output | 1 | Operation complete |

## Verification
The hardest case to reach is a `start` pulse that arrives while the unit is waiting for a memory read. It only counts if the pending read is stretched over several cycles. The bench therefore holds back `mem_rvalid` for a chosen number of cycles, injects a register-slot `start` in the middle of that wait, and then checks that the memory operation still completes with its own result and that no second `done` follows. Accumulator mode is also driven with slot bits equal to the memory code, to show that no read is issued.

// File: rtl/pfx_bitops_pkg.sv
package pfx_bitops_pkg;
    localparam int DATA_W = 8;
    localparam int OP_W   = 8;
    localparam int SLOT_W = 3;
    localparam int FLAG_W = 4;

    localparam logic [SLOT_W-1:0] SLOT_MEM = 3'd6;
    localparam logic [SLOT_W-1:0] SLOT_A   = 3'd7;

    typedef enum logic [1:0] {
        G_ROT  = 2'd0,
        G_TEST = 2'd1,
        G_CLR  = 2'd2,
        G_SET  = 2'd3
    } group_e;

    typedef enum logic [2:0] {
        K_RLC  = 3'd0,
        K_RRC  = 3'd1,
        K_RL   = 3'd2,
        K_RR   = 3'd3,
        K_SLA  = 3'd4,
        K_SRA  = 3'd5,
        K_SWAP = 3'd6,
        K_SRL  = 3'd7
    } rot_kind_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flag_t;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FETCH = 2'd1,
        S_EXEC  = 2'd2,
        S_FIN   = 2'd3
    } state_e;
endpackage

// File: rtl/pfx_rot_shift.sv
module pfx_rot_shift
    import pfx_bitops_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [DW-1:0] din,
    input  logic [2:0]    kind,
    input  logic          c_in,
    input  logic          force_z0,
    output logic [DW-1:0] dout,
    output flag_t         fl
);
    localparam int HALF = DW / 2;

    logic c_new;

    always_comb begin
        dout  = din;
        c_new = 1'b0;
        unique case (rot_kind_e'(kind))
            K_RLC: begin
                dout  = {din[DW-2:0], din[DW-1]};
                c_new = din[DW-1];
            end
            K_RRC: begin
                dout  = {din[0], din[DW-1:1]};
                c_new = din[0];
            end
            K_RL: begin
                dout  = {din[DW-2:0], c_in};
                c_new = din[DW-1];
            end
            K_RR: begin
                dout  = {c_in, din[DW-1:1]};
                c_new = din[0];
            end
            K_SLA: begin
                dout  = {din[DW-2:0], 1'b0};
                c_new = din[DW-1];
            end
            K_SRA: begin
                dout  = {din[DW-1], din[DW-1:1]};
                c_new = din[0];
            end
            K_SWAP: begin
                dout  = {din[HALF-1:0], din[DW-1:HALF]};
                c_new = 1'b0;
            end
            K_SRL: begin
                dout  = {1'b0, din[DW-1:1]};
                c_new = din[0];
            end
            default: begin
                dout  = din;
                c_new = 1'b0;
            end
        endcase
        fl.z = force_z0 ? 1'b0 : (dout == '0);
        fl.n = 1'b0;
        fl.h = 1'b0;
        fl.c = c_new;
    end
endmodule

// File: rtl/pfx_bit_ops.sv
module pfx_bit_ops
    import pfx_bitops_pkg::*;
#(
    parameter int DW = DATA_W,
    localparam int IW = $clog2(DW)
) (
    input  logic [DW-1:0] din,
    input  group_e        grp,
    input  logic [IW-1:0] idx,
    input  flag_t         fin,
    output logic [DW-1:0] dout,
    output flag_t         fout
);
    logic [DW-1:0] mask;

    for (genvar i = 0; i < DW; i++) begin : g_mask
        assign mask[i] = (idx == IW'(i));
    end

    always_comb begin
        dout = din;
        fout = fin;
        unique case (grp)
            G_TEST: begin
                dout   = din;
                fout.z = ~|(din & mask);
                fout.n = 1'b0;
                fout.h = 1'b1;
                fout.c = fin.c;
            end
            G_CLR:   dout = din & ~mask;
            G_SET:   dout = din | mask;
            default: dout = din;
        endcase
    end
endmodule

// File: rtl/pfx_bitops_unit.sv
module pfx_bitops_unit
    import pfx_bitops_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              acc_only,
    input  logic [OP_W-1:0]   sub_op,
    input  logic [DW-1:0]     rf_rdata,
    input  logic [FLAG_W-1:0] flags_in,
    output logic              mem_rd,
    input  logic              mem_rvalid,
    input  logic [DW-1:0]     mem_rdata,
    output logic              mem_wr,
    output logic [DW-1:0]     mem_wdata,
    output logic              wb_en,
    output logic [SLOT_W-1:0] wb_slot,
    output logic [DW-1:0]     wb_data,
    output logic              flags_we,
    output logic [FLAG_W-1:0] flags_out,
    output logic              done
);
    localparam int IW = $clog2(DW);

    state_e            state, nxt;
    group_e            grp_q;
    logic [2:0]        sel_q;
    logic [SLOT_W-1:0] slot_q;
    logic              acc_q;
    logic [DW-1:0]     opnd_q;
    logic [DW-1:0]     res_q;
    flag_t             fin_q;
    flag_t             fout_q;

    logic [DW-1:0] rs_out, bo_out;
    flag_t         rs_fl, bo_fl;
    logic          is_mem, writes;

    assign is_mem = (slot_q == SLOT_MEM);
    assign writes = (grp_q != G_TEST);

    pfx_rot_shift #(.DW(DW)) u_rot (
        .din      (opnd_q),
        .kind     (sel_q),
        .c_in     (fin_q.c),
        .force_z0 (acc_q),
        .dout     (rs_out),
        .fl       (rs_fl)
    );

    pfx_bit_ops #(.DW(DW)) u_bit (
        .din  (opnd_q),
        .grp  (grp_q),
        .idx  (IW'(sel_q)),
        .fin  (fin_q),
        .dout (bo_out),
        .fout (bo_fl)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start) nxt = (!acc_only && sub_op[2:0] == SLOT_MEM) ? S_FETCH : S_EXEC;
            S_FETCH: if (mem_rvalid) nxt = S_EXEC;
            S_EXEC:  nxt = S_FIN;
            S_FIN:   nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // operand capture and result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grp_q  <= G_ROT;
            sel_q  <= '0;
            slot_q <= '0;
            acc_q  <= 1'b0;
            opnd_q <= '0;
            res_q  <= '0;
            fin_q  <= '0;
            fout_q <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    grp_q  <= acc_only ? G_ROT : group_e'(sub_op[7:6]);
                    sel_q  <= sub_op[5:3];
                    slot_q <= acc_only ? SLOT_A : sub_op[2:0];
                    acc_q  <= acc_only;
                    opnd_q <= rf_rdata;
                    fin_q  <= flag_t'(flags_in);
                end
                S_FETCH: if (mem_rvalid) opnd_q <= mem_rdata;
                S_EXEC: begin
                    if (grp_q == G_ROT) begin
                        res_q  <= rs_out;
                        fout_q <= rs_fl;
                    end else begin
                        res_q  <= bo_out;
                        fout_q <= bo_fl;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_rd    = (state == S_FETCH);
        done      = (state == S_FIN);
        wb_en     = done && !is_mem && writes;
        mem_wr    = done && is_mem && writes;
        flags_we  = done && (grp_q == G_ROT || grp_q == G_TEST);
        wb_slot   = slot_q;
        wb_data   = res_q;
        mem_wdata = res_q;
        flags_out = fout_q;
    end

    // R8: read request held until data returns
    p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd && !mem_rvalid |=> mem_rd);
    // R8: memory write comes only after a read
    p_wr_after_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd) |=> !mem_wr);
    // R10: done is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6: a completion without any write carries test flags
    p_test_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done && flags_we && !wb_en && !mem_wr |-> flags_out[2:1] == 2'b01);
    // R7: clear/set always write their result somewhere
    p_clrset_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done && !flags_we |-> (wb_en || mem_wr));
    // R5: group-0 operations clear N and H
    p_rot_nh_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done && grp_q == G_ROT |-> flags_out[2:1] == 2'b00);
    // R9: accumulator mode writes A with Z clear
    p_acc_z_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done && acc_q |-> !flags_out[3] && wb_slot == SLOT_A && wb_en);
endmodule

// File: tb/sim_pfx_bitops_unit.sv
module sim_pfx_bitops_unit;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       acc_only = 1'b0;
    logic [7:0] sub_op = '0;
    logic [7:0] rf_rdata = '0;
    logic [3:0] flags_in = '0;
    logic       mem_rd;
    logic       mem_rvalid = 1'b0;
    logic [7:0] mem_rdata = '0;
    logic       mem_wr;
    logic [7:0] mem_wdata;
    logic       wb_en;
    logic [2:0] wb_slot;
    logic [7:0] wb_data;
    logic       flags_we;
    logic [3:0] flags_out;
    logic       done;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    pfx_bitops_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .acc_only(acc_only),
        .sub_op(sub_op), .rf_rdata(rf_rdata), .flags_in(flags_in),
        .mem_rd(mem_rd), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .wb_en(wb_en),
        .wb_slot(wb_slot), .wb_data(wb_data), .flags_we(flags_we),
        .flags_out(flags_out), .done(done)
    );

    // {acc, op, data, flags_in, exp_data, exp_flags, exp_wb, exp_flags_we}
    localparam logic [34:0] VEC [0:15] = '{
        {1'b0, 8'h00, 8'h85, 4'h0, 8'h0B, 4'h1, 1'b1, 1'b1}, // R2 circular left B
        {1'b0, 8'h09, 8'h01, 4'h0, 8'h80, 4'h1, 1'b1, 1'b1}, // R3 circular right C
        {1'b0, 8'h12, 8'h80, 4'h0, 8'h00, 4'h9, 1'b1, 1'b1}, // R2 left thru carry D, zero
        {1'b0, 8'h12, 8'h80, 4'h1, 8'h01, 4'h1, 1'b1, 1'b1}, // R2 carry in
        {1'b0, 8'h1B, 8'h01, 4'h1, 8'h80, 4'h1, 1'b1, 1'b1}, // R3 right thru carry E
        {1'b0, 8'h24, 8'hC0, 4'h0, 8'h80, 4'h1, 1'b1, 1'b1}, // R4 shift left H
        {1'b0, 8'h2D, 8'h81, 4'h0, 8'hC0, 4'h1, 1'b1, 1'b1}, // R4 arith right L
        {1'b0, 8'h37, 8'hA5, 4'h7, 8'h5A, 4'h0, 1'b1, 1'b1}, // R5 swap A clears C,N,H
        {1'b0, 8'h38, 8'h01, 4'h0, 8'h00, 4'h9, 1'b1, 1'b1}, // R4 logical right B
        {1'b0, 8'h37, 8'h00, 4'h1, 8'h00, 4'h8, 1'b1, 1'b1}, // R5 swap zero
        {1'b0, 8'h7F, 8'h7F, 4'h1, 8'h7F, 4'hB, 1'b0, 1'b1}, // R6 test bit7 A clear
        {1'b0, 8'h40, 8'h01, 4'hE, 8'h01, 4'h2, 1'b0, 1'b1}, // R6 test bit0 B set
        {1'b0, 8'h99, 8'hFF, 4'h5, 8'hF7, 4'h5, 1'b1, 1'b0}, // R7 clear bit3 C
        {1'b0, 8'hEA, 8'h00, 4'hA, 8'h20, 4'hA, 1'b1, 1'b0}, // R7 set bit5 D
        {1'b1, 8'h06, 8'h00, 4'h8, 8'h00, 4'h0, 1'b1, 1'b1}, // R9 acc circular left
        {1'b1, 8'h18, 8'h01, 4'h0, 8'h00, 4'h1, 1'b1, 1'b1}  // R9 acc right thru carry
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_reg(input logic [34:0] v);
        logic [2:0] eslot;
        eslot = v[34] ? 3'd7 : v[28:26];
        acc_only = v[34]; sub_op = v[33:26]; rf_rdata = v[25:18]; flags_in = v[17:14];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0; rf_rdata = 8'h5C;
        check("R9 no memory read", {31'd0, mem_rd}, 32'd0);
        check("R1 not done early", {31'd0, done}, 32'd0);
        @(negedge clk);
        check("R1 done latency", {31'd0, done}, 32'd1);
        check("R1 wb_slot", {29'd0, wb_slot}, {29'd0, eslot});
        check("R2 R3 R4 R5 R7 data", {24'd0, wb_data}, {24'd0, v[13:6]});
        check("R5 R6 R9 flags", {28'd0, flags_out}, {28'd0, v[5:2]});
        check("R6 R7 wb_en", {31'd0, wb_en}, {31'd0, v[1]});
        check("R6 R7 flags_we", {31'd0, flags_we}, {31'd0, v[0]});
        check("R8 no mem write", {31'd0, mem_wr}, 32'd0);
        @(negedge clk);
        check("R10 done pulse", {31'd0, done}, 32'd0);
        acc_only = 1'b0;
    endtask

    task automatic run_mem(input logic [7:0] op, input logic [7:0] data, input logic [3:0] fin,
                           input int wait_n, input bit inject,
                           input logic [7:0] ewd, input logic [3:0] ef,
                           input logic ewr, input logic efwe);
        acc_only = 1'b0; sub_op = op; flags_in = fin; rf_rdata = 8'hEE;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R8 read requested", {31'd0, mem_rd}, 32'd1);
        for (int i = 0; i < wait_n; i++) begin
            if (inject && i == 0) begin
                start = 1'b1; sub_op = 8'hC0; rf_rdata = 8'h00; flags_in = 4'h0;
            end
            @(negedge clk);
            start = 1'b0;
            check("R8 R10 read held", {31'd0, mem_rd}, 32'd1);
        end
        mem_rvalid = 1'b1; mem_rdata = data;
        @(negedge clk);
        mem_rvalid = 1'b0; mem_rdata = 8'h00;
        check("R8 read released", {31'd0, mem_rd}, 32'd0);
        check("R8 not done yet", {31'd0, done}, 32'd0);
        @(negedge clk);
        check("R8 done", {31'd0, done}, 32'd1);
        check("R6 R8 mem_wr", {31'd0, mem_wr}, {31'd0, ewr});
        if (ewr) check("R8 R10 mem_wdata", {24'd0, mem_wdata}, {24'd0, ewd});
        check("R8 no register write", {31'd0, wb_en}, 32'd0);
        check("R6 R7 flags_we mem", {31'd0, flags_we}, {31'd0, efwe});
        check("R6 R8 flags mem", {28'd0, flags_out}, {28'd0, ef});
        @(negedge clk);
        check("R10 no extra op", {31'd0, done}, 32'd0);
        check("R10 idle after mem", {30'd0, mem_rd, mem_wr}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset done", {31'd0, done}, 32'd0);
        check("R11 reset strobes", {28'd0, wb_en, flags_we, mem_rd, mem_wr}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 idle after reset", {31'd0, done}, 32'd0);
        for (int k = 0; k < 16; k++) run_reg(VEC[k]);
        // R7 set bit0 of memory, with start injected mid-read (R10)
        run_mem(8'hC6, 8'h10, 4'h3, 3, 1'b1, 8'h11, 4'h3, 1'b1, 1'b0);
        // R6 test bit4 of memory: read only
        run_mem(8'h66, 8'h10, 4'h0, 1, 1'b0, 8'h00, 4'h2, 1'b0, 1'b1);
        // R2 circular left of memory, data immediately valid
        run_mem(8'h06, 8'h80, 4'h0, 0, 1'b0, 8'h01, 4'h1, 1'b1, 1'b1);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule